// File: doc/BRIEF.md
# Tagged Local-History Direction Predictor

This block guesses whether a conditional branch will be taken, using that branch's own recent outcomes. A direct-mapped cache, looked up by branch address, holds one entry per tracked branch. Each entry has a partial tag, a committed outcome history and a speculative copy of that history. The history in use, joined with or folded into low address bits, selects one 2-bit saturating counter. All branches share a single counter table. The prediction is the most significant bit of the selected counter.

A fetch stage asks for a prediction on the predict port and gets the answer in the same cycle. A prediction that hits also shifts its own guess into the entry's speculative history. Later lookups of the same branch then see that guess before the branch has resolved. The back end reports each outcome on the resolve port. A resolve commits the real history, trains the counter, allocates a new entry on a tag miss, and repairs the speculative history after a mispredict.

Top module: `bp_local_hist`

## Requirements
- R1: After reset every cache entry is invalid, and every counter holds weak-taken (2'b10).
- R2: A lookup whose tag does not match a valid entry returns pred_hit=0 and pred_taken=0, and it changes no state.
- R3: A resolve that misses fills the indexed entry with the resolve tag, a zero history and the speculation flag clear, and it leaves all counters unchanged. A lookup of that address hits from the next cycle.
- R4: Address bits [IDX_W-1:0] select the cache entry and bits [IDX_W+TAG_W-1:IDX_W] form the tag. A second branch with the same index and a different tag misses, and its own resolve replaces the old entry.
- R5: On a hit, pred_taken is bit 1 of the counter selected by the history in use. With the default index mode, the counter index is {history, addr[CAT_W-1:0]}. A parameter instead selects the history alone or the history XORed with addr[HIST_W-1:0].
- R6: Counter codes are 00 strong not-taken, 01 weak not-taken, 10 weak taken and 11 strong taken. A taken outcome adds one and a not-taken outcome subtracts one. Counters saturate at 11 and at 00.
- R7: A valid lookup that hits shifts its predicted direction into the entry's speculative history at bit 0 and sets the speculation flag. While that flag is set, lookups use the speculative history instead of the committed one.
- R8: Counters change only on resolves that hit. Lookups never change a counter.
- R9: A resolve that hits trains the counter indexed by the committed history before the shift and the resolve address. It then shifts the actual outcome into bit 0 of the committed history.
- R10: A mispredicting resolve copies the new committed history into the speculative history and clears the flag. A correct resolve clears the flag when the speculative history equals the new committed history.
- R11: When a lookup and a resolve address the same entry in one cycle, a mispredicting or allocating resolve cancels the lookup's speculative shift. Otherwise both updates apply.
- R12: The prediction is combinational on the current state. With no lookup and no resolve, the outputs for an unchanged address stay the same from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_valid | input | 1 | Lookup request; a hit updates the speculative history |
| pred_addr | input | IDX_W+TAG_W | Address of the branch being looked up |
| pred_hit | output | 1 | The lookup matched a valid entry |
| pred_taken | output | 1 | Predicted direction (1 = taken) |
| res_valid | input | 1 | Resolve request |
| res_addr | input | IDX_W+TAG_W | Address of the resolved branch |
| res_taken | input | 1 | Actual outcome (1 = taken) |
| res_mispred | input | 1 | The earlier prediction for this branch was wrong |

## Verification
pred_hit and pred_taken are due in the cycle the lookup address is applied. The bench drives each step at the falling edge and samples the outputs 1 ns later, before the next rising edge. Every state change a lookup or resolve makes becomes visible at the rising edge that ends the step. Each check therefore reads the result of the preceding steps only, and the expected values follow step by step from the counter and history rules. Same-cycle lookup/resolve conflicts are driven in a single step, and the bench inspects their effect one step later.

// File: rtl/bp_lh_pkg.sv
package bp_lh_pkg;
    // counter index mode selection
    localparam int MODE_HIST = 0;
    localparam int MODE_CAT  = 1;
    localparam int MODE_XOR  = 2;

    // counter codes
    localparam logic [1:0] CTR_SNT = 2'b00;
    localparam logic [1:0] CTR_WT  = 2'b10;
    localparam logic [1:0] CTR_ST  = 2'b11;
endpackage

// File: rtl/bp_cnt_idx.sv
module bp_cnt_idx
    import bp_lh_pkg::*;
#(
    parameter int HIST_W = 6,
    parameter int LO_W   = 4,
    parameter int MODE   = MODE_CAT,
    parameter int CIDX_W = 10
) (
    input  logic [HIST_W-1:0] hist,
    input  logic [LO_W-1:0]   addr_lo,
    output logic [CIDX_W-1:0] cidx
);
    generate
        if (MODE == MODE_CAT) begin : g_cat
            assign cidx = {hist, addr_lo};
        end else if (MODE == MODE_XOR) begin : g_xor
            assign cidx = hist ^ addr_lo;
        end else begin : g_hist
            logic unused_lo;
            assign unused_lo = ^addr_lo;
            assign cidx = hist;
        end
    endgenerate
endmodule

// File: rtl/bp_sat_ctr.sv
module bp_sat_ctr
    import bp_lh_pkg::*;
(
    input  logic [1:0] cur,
    input  logic       up,
    output logic [1:0] nxt
);
    always_comb begin
        nxt = cur;
        if (up) begin
            if (cur != CTR_ST) nxt = cur + 2'd1;
        end else begin
            if (cur != CTR_SNT) nxt = cur - 2'd1;
        end
    end
endmodule

// File: rtl/bp_local_hist.sv
module bp_local_hist
    import bp_lh_pkg::*;
#(
    parameter int IDX_W  = 10,
    parameter int TAG_W  = 8,
    parameter int HIST_W = 6,
    parameter int CAT_W  = 4,
    parameter int MODE   = MODE_CAT
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pred_valid,
    input  logic [IDX_W+TAG_W-1:0] pred_addr,
    output logic                   pred_hit,
    output logic                   pred_taken,
    input  logic                   res_valid,
    input  logic [IDX_W+TAG_W-1:0] res_addr,
    input  logic                   res_taken,
    input  logic                   res_mispred
);
    localparam int ENTRIES = 1 << IDX_W;
    localparam int CIDX_W  = (MODE == MODE_CAT) ? HIST_W + CAT_W : HIST_W;
    localparam int CTRS    = 1 << CIDX_W;
    localparam int LO_W    = (MODE == MODE_CAT) ? CAT_W : HIST_W;

    typedef struct packed {
        logic              vld;
        logic [TAG_W-1:0]  tag;
        logic [HIST_W-1:0] hist;
        logic [HIST_W-1:0] spec_hist;
        logic              spec;
    } ent_t;

    typedef struct packed {
        ent_t [ENTRIES-1:0]    ent;
        logic [CTRS-1:0][1:0]  ctr;
    } st_t;

    st_t st_d, st_q;

    // ---------------- lookup path ----------------
    logic [IDX_W-1:0]  p_idx;
    logic [TAG_W-1:0]  p_tag;
    ent_t              p_ent;
    logic [HIST_W-1:0] p_use_hist;
    logic [CIDX_W-1:0] p_cidx;
    logic [HIST_W-1:0] p_spec_nxt;

    assign p_idx      = pred_addr[IDX_W-1:0];
    assign p_tag      = pred_addr[IDX_W+TAG_W-1:IDX_W];
    assign p_ent      = st_q.ent[p_idx];
    assign pred_hit   = p_ent.vld && (p_ent.tag == p_tag);
    assign p_use_hist = p_ent.spec ? p_ent.spec_hist : p_ent.hist;

    bp_cnt_idx #(
        .HIST_W(HIST_W), .LO_W(LO_W), .MODE(MODE), .CIDX_W(CIDX_W)
    ) u_pidx (
        .hist(p_use_hist), .addr_lo(pred_addr[LO_W-1:0]), .cidx(p_cidx)
    );

    assign pred_taken = pred_hit && st_q.ctr[p_cidx][1];
    assign p_spec_nxt = {p_use_hist[HIST_W-2:0], pred_taken};

    // ---------------- resolve path ----------------
    logic [IDX_W-1:0]  r_idx;
    logic [TAG_W-1:0]  r_tag;
    ent_t              r_ent;
    logic              r_hit;
    logic [CIDX_W-1:0] r_cidx;
    logic [1:0]        r_ctr_nxt;
    logic [HIST_W-1:0] r_new_hist;
    logic              p_cancel;

    assign r_idx      = res_addr[IDX_W-1:0];
    assign r_tag      = res_addr[IDX_W+TAG_W-1:IDX_W];
    assign r_ent      = st_q.ent[r_idx];
    assign r_hit      = r_ent.vld && (r_ent.tag == r_tag);
    assign r_new_hist = {r_ent.hist[HIST_W-2:0], res_taken};

    bp_cnt_idx #(
        .HIST_W(HIST_W), .LO_W(LO_W), .MODE(MODE), .CIDX_W(CIDX_W)
    ) u_ridx (
        .hist(r_ent.hist), .addr_lo(res_addr[LO_W-1:0]), .cidx(r_cidx)
    );

    bp_sat_ctr u_sat (
        .cur(st_q.ctr[r_cidx]), .up(res_taken), .nxt(r_ctr_nxt)
    );

    assign p_cancel = res_valid && (r_idx == p_idx) && (res_mispred || !r_hit);

    // ---------------- next state ----------------
    always_comb begin
        st_d = st_q;
        if (res_valid) begin
            if (r_hit) begin
                st_d.ctr[r_cidx]     = r_ctr_nxt;
                st_d.ent[r_idx].hist = r_new_hist;
                if (res_mispred) begin
                    st_d.ent[r_idx].spec_hist = r_new_hist;
                    st_d.ent[r_idx].spec      = 1'b0;
                end else if (r_ent.spec && (r_ent.spec_hist == r_new_hist)) begin
                    st_d.ent[r_idx].spec      = 1'b0;
                end
            end else begin
                st_d.ent[r_idx] = '{vld: 1'b1, tag: r_tag, hist: '0,
                                    spec_hist: '0, spec: 1'b0};
            end
        end
        if (pred_valid && pred_hit && !p_cancel) begin
            st_d.ent[p_idx].spec_hist = p_spec_nxt;
            st_d.ent[p_idx].spec      = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ent <= '0;
            st_q.ctr <= {CTRS{CTR_WT}};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/bp_lh_chk.sv
module bp_lh_chk #(
    parameter int AW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pred_valid,
    input logic [AW-1:0] pred_addr,
    input logic          pred_hit,
    input logic          pred_taken,
    input logic          res_valid,
    input logic [AW-1:0] res_addr
);
    logic seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else if (res_valid) seen_q <= 1'b1;
    end

    AST_MISS_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_hit |-> !pred_taken); // R2

    AST_FRESH_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> !pred_hit); // R1

    AST_ALLOC_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid ##1 (pred_addr == $past(res_addr)) |-> pred_hit); // R3

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!pred_valid && !res_valid) ##1 $stable(pred_addr)
        |-> $stable(pred_hit) && $stable(pred_taken)); // R12
endmodule

bind bp_local_hist bp_lh_chk #(.AW(IDX_W + TAG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pred_addr(pred_addr),
    .pred_hit(pred_hit), .pred_taken(pred_taken), .res_valid(res_valid),
    .res_addr(res_addr)
);

// File: tb/sim_bp_local_hist.sv
`timescale 1ns/1ps
module sim_bp_local_hist;
    localparam int AW = 18;
    localparam logic [AW-1:0] A_AD = 18'h00405; // idx 5, tag 1
    localparam logic [AW-1:0] B_AD = 18'h00809; // idx 9, tag 2
    localparam logic [AW-1:0] C_AD = 18'h00C05; // idx 5, tag 3
    localparam logic [AW-1:0] D_AD = 18'h01014; // idx 20, tag 4
    localparam logic [AW-1:0] E_AD = 18'h01405; // idx 5, tag 5
    localparam logic [AW-1:0] Z_AD = 18'h00000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic pred_valid = 1'b0, res_valid = 1'b0, res_taken = 1'b0, res_mispred = 1'b0;
    logic [AW-1:0] pred_addr = '0, res_addr = '0;
    logic pred_hit, pred_taken;
    int checks = 0, errors = 0;

    always #2 clk = ~clk;

    bp_local_hist u0 (
        .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pred_addr(pred_addr),
        .pred_hit(pred_hit), .pred_taken(pred_taken), .res_valid(res_valid),
        .res_addr(res_addr), .res_taken(res_taken), .res_mispred(res_mispred)
    );

    typedef struct packed {
        logic          pv;
        logic [AW-1:0] pa;
        logic          rv;
        logic [AW-1:0] ra;
        logic          rt;
        logic          rm;
        logic          chk;
        logic          eh;
        logic          et;
        logic [23:0]   req;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VECS [NV] = '{
        '{1'b1, A_AD, 1'b0, Z_AD, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R2"},  // miss
        '{1'b0, Z_AD, 1'b1, A_AD, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R3"},  // allocate A
        '{1'b1, A_AD, 1'b0, Z_AD, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R5"},  // ctr[5]=10
        '{1'b1, A_AD, 1'b0, Z_AD, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R7"},  // spec 000001
        '{1'b0, Z_AD, 1'b1, A_AD, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R9"},  // ctr[5]->11
        '{1'b0, Z_AD, 1'b1, A_AD, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R9"},  // ctr[0x15]->11
        '{1'b1, A_AD, 1'b0, Z_AD, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R9"},  // hist 000011
        '{1'b0, Z_AD, 1'b1, A_AD, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R10"}, // ctr[0x35]->01
        '{1'b1, A_AD, 1'b0, Z_AD, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R10"}, // hist 000110
        '{1'b0, Z_AD, 1'b1, B_AD, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R3"},  // allocate B
        '{1'b1, B_AD, 1'b0, Z_AD, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R3"},  // hist 0, spec 000001
        '{1'b0, Z_AD, 1'b1, B_AD, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R10"}, // ctr[9]->01, spec reset
        '{1'b1, B_AD, 1'b0, Z_AD, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R10"}, // uses hist 0
        '{1'b0, Z_AD, 1'b1, B_AD, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6"},  // ctr[9]->00
        '{1'b0, Z_AD, 1'b1, B_AD, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R6"},  // stays 00
        '{1'b1, B_AD, 1'b0, Z_AD, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R6"},  // floor held
        '{1'b0, Z_AD, 1'b1, B_AD, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R6"},  // ctr[9]->01
        '{1'b1, B_AD, 1'b0, Z_AD, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R9"},  // hist 000001
        '{1'b1, C_AD, 1'b0, Z_AD, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R4"},  // tag mismatch
        '{1'b0, Z_AD, 1'b1, C_AD, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R4"},  // replace A by C
        '{1'b1, A_AD, 1'b0, Z_AD, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R4"},  // A evicted
        '{1'b1, C_AD, 1'b0, Z_AD, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R4"},  // shared ctr[5]=11
        '{1'b0, Z_AD, 1'b1, C_AD, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R6"},  // ctr[5] stays 11
        '{1'b0, Z_AD, 1'b1, C_AD, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R10"}, // hist 000010
        '{1'b1, C_AD, 1'b0, Z_AD, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R9"},  // ctr[0x25]=10
        '{1'b0, Z_AD, 1'b1, E_AD, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R4"},  // E replaces C
        '{1'b0, Z_AD, 1'b1, E_AD, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R6"},  // ctr[5] 11->10
        '{1'b1, E_AD, 1'b0, Z_AD, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R6"},  // ceiling held
        '{1'b1, E_AD, 1'b0, Z_AD, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R7"},  // spec 000001
        '{1'b0, Z_AD, 1'b1, E_AD, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R8"},  // ctr[5] 10->01
        '{1'b1, E_AD, 1'b0, Z_AD, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R8"},  // lookups left ctr alone
        '{1'b0, E_AD, 1'b0, Z_AD, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R12"}  // idle read
    };

    task automatic check(input logic eh, input logic et, input logic [23:0] req);
        checks++;
        if (pred_hit !== eh || pred_taken !== et) begin
            errors++;
            $display("FAIL %s: hit/taken = %b/%b, expected %b/%b", req, pred_hit, pred_taken, eh, et);
        end
    endtask

    task automatic step(input vec_t v);
        @(negedge clk);
        pred_valid = v.pv; pred_addr = v.pa;
        res_valid = v.rv; res_addr = v.ra; res_taken = v.rt; res_mispred = v.rm;
        #1;
        if (v.chk) check(v.eh, v.et, v.req);
        @(posedge clk);
    endtask

    initial begin
        #800000;
        checks++; errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: all entries empty after reset
        step('{1'b1, A_AD, 1'b0, Z_AD, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R1"});
        step('{1'b1, D_AD, 1'b0, Z_AD, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R1"});
        step('{1'b0, Z_AD, 1'b0, Z_AD, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R1"});

        for (int i = 0; i < NV; i++) step(VECS[i]);
        // R12: same address, still idle, unchanged outputs
        step('{1'b0, E_AD, 1'b0, Z_AD, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R12"});

        // R11: lookup and mispredicting resolve on the same entry together
        step('{1'b0, Z_AD, 1'b1, D_AD, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R11"});
        step('{1'b1, D_AD, 1'b1, D_AD, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R11"});
        // shift cancelled: hist 0 selects ctr[4]=01 -> not taken
        step('{1'b1, D_AD, 1'b0, Z_AD, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R11"});

        // R1: reset in mid-run clears entries and restores counters
        @(negedge clk); rst_n = 1'b0; pred_valid = 1'b0; res_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        step('{1'b1, E_AD, 1'b0, Z_AD, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R1"});
        step('{1'b0, Z_AD, 1'b1, E_AD, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R1"});
        step('{1'b1, E_AD, 1'b0, Z_AD, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, "R1"});

        @(negedge clk); pred_valid = 1'b0; res_valid = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule